// File: doc/BRIEF.md
# Wormhole Switch Arbiter with Redundant Link Groups

This block decides, for a packet router with a parameter number of ports, which output each arriving packet is connected to. Every input port presents a request together with the first byte of its packet. A small header value names one output port directly; a larger value is an index into a routing table. Each table entry is a set of equivalent output links. The block connects the input to one idle and healthy member of that set. Inputs that compete for the same output are served in round-robin order.

A connection works like a wormhole. The input keeps its output until an end-of-packet marker arrives on that input, and a normal marker and an error marker release it in the same way. When every member of the requested set is reported failed, or the set is empty, the input is marked for discard until its packet ends. When a healthy member exists but all of them are taken, the input waits without any flag. The data crossbar and the packet buffers sit outside the block and follow its `grant`, `sel` and `discard` outputs.

Top module: `wsw_switch_arbiter`

## Requirements
- R1: In the first cycle after reset, `grant` and `discard` are all zero and every routing table entry is the empty set.
- R2: A header below 32 (LOG_BASE) names an output directly. If the value is below N, the set holds only that output. If the value is N or more, the set is empty.
- R3: A header of 32 or above selects the table entry `hdr - 32`, an N-bit mask in which bit k stands for output k. The chosen output is the lowest-numbered member that is idle and healthy. `grant[i]` rises one clock after the request is presented, and `sel[i]` carries the output index.
- R4: A member whose `link_ok` bit is low is never chosen. The input fails over to another healthy member of the same set.
- R5: If no member of the set is healthy, including the case of an empty set, `discard[i]` rises one clock after the request and stays high until that input's end of packet.
- R6: If healthy members exist but all are connected, the input waits with `grant[i]` and `discard[i]` low. It is connected the clock after an output of its set becomes free.
- R7: When several inputs target the same output in one cycle, that output goes to the first requester above the input it last granted, wrapping at N. The search starts at input 0 after reset.
- R8: While connected, `grant[i]` and `sel[i]` hold regardless of `req`, `hdr` or `link_ok`. Two inputs never hold the same output.
- R9: `eop[i]` or `eep[i]` on a connected or discarding input ends the state at the next clock. The freed output can be granted again one clock later.
- R10: A table write with `tbl_we` high stores `tbl_mask` at entry `tbl_addr - 32` at the clock edge. A lookup in the same cycle sees the old entry. Writes to addresses below 32 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Per-input request: header valid |
| hdr | input | N*HDR_W | Per-input leading header byte, input i at bits [i*HDR_W +: HDR_W] |
| eop | input | N | Per-input normal end of packet |
| eep | input | N | Per-input error end of packet |
| link_ok | input | N | Per-output link health, 1 = usable |
| tbl_we | input | 1 | Routing table write enable |
| tbl_addr | input | HDR_W | Logical address to program (32 or above) |
| tbl_mask | input | N | Output set stored for that address |
| grant | output | N | Input i is connected |
| sel | output | N*IW | Output index per input, valid while grant is high |
| discard | output | N | Input i's packet is to be dropped |

## Verification
Each decision is registered. A request or header driven in a cycle shows up as `grant`, `sel` or `discard` after exactly one clock edge. A release through either end-of-packet marker clears the input after one edge, and a waiting input takes the freed output one edge after that. A table write affects lookups from the following cycle. The bench drives every input just after a rising edge and advances a reference model by the same single step. It compares all outputs a fixed 2 ns after the next rising edge, so every result is checked in the cycle it is due.

// File: rtl/wsw_pkg.sv
`timescale 1ns/1ps
package wsw_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_CONN = 2'd1,
        PS_DROP = 2'd2
    } pstate_e;

    // lowest set bit among the low n bits, -1 when none
    function automatic int first_one(input logic [31:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            if (v[k]) return k;
        end
        return -1;
    endfunction

    // round-robin pick: first set bit above 'last', wrapping at n
    function automatic int rr_pick(input logic [31:0] v, input int last, input int n);
        for (int k = 1; k <= n; k++) begin
            if (v[(last + k) % n]) return (last + k) % n;
        end
        return -1;
    endfunction

endpackage

// File: rtl/wsw_route_table.sv
`timescale 1ns/1ps
module wsw_route_table #(
    parameter int N        = 4,
    parameter int HDR_W    = 8,
    parameter int LOG_BASE = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [HDR_W-1:0]   waddr,
    input  logic [N-1:0]       wmask,
    input  logic [N*HDR_W-1:0] hdr_flat,
    output logic [N*N-1:0]     grp_flat
);
    localparam int DEPTH = (1 << HDR_W) - LOG_BASE;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [N-1:0] tab [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++) tab[e] <= '0;
        end else if (we && (waddr >= HDR_W'(LOG_BASE))) begin
            tab[AW'(waddr - HDR_W'(LOG_BASE))] <= wmask;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_look
        logic [HDR_W-1:0] h;
        logic [N-1:0]     grp;
        assign h = hdr_flat[i*HDR_W +: HDR_W];
        always_comb begin
            if (h < HDR_W'(LOG_BASE)) begin
                grp = (h < HDR_W'(N)) ? (N'(1) << h) : '0;
            end else begin
                grp = tab[AW'(h - HDR_W'(LOG_BASE))];
            end
        end
        assign grp_flat[i*N +: N] = grp;
    end
endmodule

// File: rtl/wsw_rr_arb.sv
`timescale 1ns/1ps
module wsw_rr_arb
    import wsw_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;
    int            win;

    always_comb begin
        win = rr_pick(32'(req), int'(last_q), N);
        gnt = (win >= 0) ? (N'(1) << win) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)           last_q <= IW'(N - 1);
        else if (win >= 0) last_q <= IW'(win);
    end
endmodule

// File: rtl/wsw_switch_arbiter.sv
`timescale 1ns/1ps
module wsw_switch_arbiter
    import wsw_pkg::*;
#(
    parameter int N        = 4,
    parameter int HDR_W    = 8,
    parameter int LOG_BASE = 32,
    localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       req,
    input  logic [N*HDR_W-1:0] hdr,
    input  logic [N-1:0]       eop,
    input  logic [N-1:0]       eep,
    input  logic [N-1:0]       link_ok,
    input  logic               tbl_we,
    input  logic [HDR_W-1:0]   tbl_addr,
    input  logic [N-1:0]       tbl_mask,
    output logic [N-1:0]       grant,
    output logic [N*IW-1:0]    sel,
    output logic [N-1:0]       discard
);
    pstate_e       st_q  [N];
    logic [IW-1:0] out_q [N];

    logic [N*N-1:0] grp_flat;
    logic [N-1:0]   busy;
    logic [N-1:0]   want, drop;
    logic [IW-1:0]  tgt [N];
    logic [N-1:0]   arb_req [N];
    logic [N-1:0]   arb_gnt [N];
    logic [N-1:0]   won;

    wsw_route_table #(.N(N), .HDR_W(HDR_W), .LOG_BASE(LOG_BASE)) u_table (
        .clk      (clk),
        .rst      (rst),
        .we       (tbl_we),
        .waddr    (tbl_addr),
        .wmask    (tbl_mask),
        .hdr_flat (hdr),
        .grp_flat (grp_flat)
    );

    // outputs held by live connections
    always_comb begin
        busy = '0;
        for (int i = 0; i < N; i++) begin
            if (st_q[i] == PS_CONN) busy[out_q[i]] = 1'b1;
        end
    end

    // per-input choice of a target output
    for (genvar i = 0; i < N; i++) begin : g_in
        logic [N-1:0] healthy, cand;
        int           pick;
        always_comb begin
            healthy = grp_flat[i*N +: N] & link_ok;
            cand    = healthy & ~busy;
            pick    = first_one(32'(cand), N);
            tgt[i]  = (pick >= 0) ? IW'(pick) : '0;
            want[i] = (st_q[i] == PS_IDLE) && req[i] && (pick >= 0);
            drop[i] = (st_q[i] == PS_IDLE) && req[i] && (healthy == '0);
        end
    end

    // one round-robin arbiter per output
    for (genvar o = 0; o < N; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < N; i++) begin
                arb_req[o][i] = want[i] && (tgt[i] == IW'(o));
            end
        end
        wsw_rr_arb #(.N(N)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (arb_req[o]),
            .gnt (arb_gnt[o])
        );
    end

    always_comb begin
        won = '0;
        for (int o = 0; o < N; o++) won = won | arb_gnt[o];
    end

    for (genvar i = 0; i < N; i++) begin : g_fsm
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]  <= PS_IDLE;
                out_q[i] <= '0;
            end else begin
                unique case (st_q[i])
                    PS_IDLE: begin
                        if (won[i]) begin
                            st_q[i]  <= PS_CONN;
                            out_q[i] <= tgt[i];
                        end else if (drop[i]) begin
                            st_q[i]  <= PS_DROP;
                        end
                    end
                    PS_CONN, PS_DROP: begin
                        if (eop[i] || eep[i]) st_q[i] <= PS_IDLE;
                    end
                    default: st_q[i] <= PS_IDLE;
                endcase
            end
        end
        assign grant[i]             = (st_q[i] == PS_CONN);
        assign discard[i]           = (st_q[i] == PS_DROP);
        assign sel[i*IW +: IW]      = out_q[i];
    end
endmodule

// File: rtl/wsw_switch_arbiter_chk.sv
`timescale 1ns/1ps
module wsw_switch_arbiter_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    eop,
    input logic [N-1:0]    eep,
    input logic [N-1:0]    link_ok,
    input logic [N-1:0]    grant,
    input logic [N*IW-1:0] sel,
    input logic [N-1:0]    discard
);
    logic [N-1:0] ok_prev;
    logic [N-1:0] sel_ok_prev;
    logic         clash;

    always_ff @(posedge clk) ok_prev <= link_ok;

    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < N; i++) begin
            sel_ok_prev[i] = ok_prev[sel[i*IW +: IW]];
            for (int j = i + 1; j < N; j++) begin
                if (grant[i] && grant[j] && sel[i*IW +: IW] == sel[j*IW +: IW]) clash = 1'b1;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) $fell(rst) |-> (grant == '0 && discard == '0));

    // R8
    no_shared_output_chk: assert property (@(posedge clk) disable iff (rst) !clash);

    // R5
    grant_xor_discard_chk: assert property (@(posedge clk) disable iff (rst) (grant & discard) == '0);

    for (genvar i = 0; i < N; i++) begin : g_p
        // R8
        hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
            (grant[i] && !eop[i] && !eep[i]) |=> (grant[i] && $stable(sel[i*IW +: IW])));
        // R9
        release_chk: assert property (@(posedge clk) disable iff (rst)
            ((grant[i] || discard[i]) && (eop[i] || eep[i])) |=> (!grant[i] && !discard[i]));
        // R4
        healthy_pick_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(grant[i]) |-> sel_ok_prev[i]);
    end
endmodule

bind wsw_switch_arbiter wsw_switch_arbiter_chk #(.N(N), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .eop(eop), .eep(eep), .link_ok(link_ok),
    .grant(grant), .sel(sel), .discard(discard)
);

// File: tb/test_wsw_switch_arbiter.sv
`timescale 1ns/1ps
module test_wsw_switch_arbiter;
    localparam int N = 4, HDR_W = 8, LB = 32, IW = 2, DEPTH = 256 - LB;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N-1:0]       req = '0, eop = '0, eep = '0, link_ok = '1;
    logic [N*HDR_W-1:0] hdr = '0;
    logic               tbl_we = 1'b0;
    logic [HDR_W-1:0]   tbl_addr = '0;
    logic [N-1:0]       tbl_mask = '0;
    logic [N-1:0]       grant, discard;
    logic [N*IW-1:0]    sel;

    int total = 0, bad = 0;

    // reference model: 0 idle, 1 connected, 2 discarding
    int           mst [N];
    int           mout [N];
    int           mlast [N];
    logic [N-1:0] mtab [DEPTH];

    always #2.5 clk = ~clk;

    wsw_switch_arbiter #(.N(N), .HDR_W(HDR_W), .LOG_BASE(LB)) i_wsw_switch_arbiter (
        .clk(clk), .rst(rst), .req(req), .hdr(hdr), .eop(eop), .eep(eep),
        .link_ok(link_ok), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask),
        .grant(grant), .sel(sel), .discard(discard)
    );

    function automatic logic [N-1:0] group_of(input int h);
        if (h < LB) return (h < N) ? (N'(1) << h) : '0;
        return mtab[h - LB];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin mst[i] = 0; mout[i] = 0; mlast[i] = N - 1; end
        for (int e = 0; e < DEPTH; e++) mtab[e] = '0;
    endtask

    task automatic check_now(input string tag);
        logic [N-1:0]    eg, ed;
        logic [N*IW-1:0] es, as;
        eg = '0; ed = '0; es = '0; as = '0;
        for (int i = 0; i < N; i++) begin
            eg[i] = (mst[i] == 1);
            ed[i] = (mst[i] == 2);
            if (eg[i]) es[i*IW +: IW] = IW'(mout[i]);
            if (grant[i]) as[i*IW +: IW] = sel[i*IW +: IW];
        end
        total++;
        if (grant !== eg || discard !== ed || as !== es) begin
            bad++;
            $display("FAIL %s: grant=%b discard=%b sel=%h expected grant=%b discard=%b sel=%h",
                     tag, grant, discard, as, eg, ed, es);
        end
    endtask

    // advance model one clock with the inputs now driven, then compare
    task automatic step(input string tag);
        int           nst [N];
        int           nout [N];
        int           want [N];
        logic [N-1:0] busy, healthy, cand;
        busy = '0;
        for (int i = 0; i < N; i++) begin
            nst[i] = mst[i]; nout[i] = mout[i]; want[i] = -1;
            if (mst[i] == 1) busy[mout[i]] = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            if (mst[i] == 0 && req[i]) begin
                healthy = group_of(int'(hdr[i*HDR_W +: HDR_W])) & link_ok;
                cand    = healthy & ~busy;
                if (healthy == '0) nst[i] = 2;
                else for (int k = N - 1; k >= 0; k--) if (cand[k]) want[i] = k;
            end else if (mst[i] != 0 && (eop[i] || eep[i])) begin
                nst[i] = 0;
            end
        end
        for (int o = 0; o < N; o++) begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (mlast[o] + k) % N;
                if (want[c] == o) begin
                    nst[c] = 1; nout[c] = o; mlast[o] = c;
                    break;
                end
            end
        end
        if (tbl_we && tbl_addr >= LB) mtab[tbl_addr - LB] = tbl_mask;
        @(posedge clk);
        #2;
        for (int i = 0; i < N; i++) begin mst[i] = nst[i]; mout[i] = nout[i]; end
        check_now(tag);
    endtask

    task automatic set_hdr(input int i, input int v);
        hdr[i*HDR_W +: HDR_W] = HDR_W'(v);
    endtask

    task automatic idle_inputs();
        req = '0; eop = '0; eep = '0; tbl_we = 1'b0;
    endtask

    task automatic release_all(input string tag);
        idle_inputs(); eop = '1; step(tag); eop = '0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk); #2;
        check_now("R1 reset state");

        // R1: unprogrammed logical entry is empty -> discard
        req[0] = 1; set_hdr(0, 40); step("R1 empty table");
        release_all("R9 release");

        // R10: program entry 40 = {1,2}; address below 32 ignored
        tbl_we = 1; tbl_addr = 8'd40; tbl_mask = 4'b0110;
        req[1] = 1; set_hdr(1, 40); step("R10 same-cycle lookup uses old");
        release_all("R9");
        tbl_we = 1; tbl_addr = 8'd3; tbl_mask = 4'b0000; step("R10 low addr write");
        tbl_we = 0; req[2] = 1; set_hdr(2, 3); step("R10 low addr ignored, R2 physical");
        release_all("R9");

        // R2: physical direct and out of range
        req[0] = 1; set_hdr(0, 2); req[1] = 1; set_hdr(1, 9); step("R2 physical");
        release_all("R9");

        // R3: logical lowest idle healthy member
        req[1] = 1; set_hdr(1, 40); step("R3 logical");
        release_all("R9");

        // R4: failover
        link_ok = 4'b1101; req[1] = 1; set_hdr(1, 40); step("R4 failover");
        release_all("R9");

        // R5: all members failed -> discard held until eop
        link_ok = 4'b1001; req[3] = 1; set_hdr(3, 40); step("R5 discard");
        req[3] = 0; step("R5 discard held");
        eep[3] = 1; step("R9 eep ends discard"); eep[3] = 0;
        link_ok = '1;

        // R6: wait while members busy
        req[0] = 1; set_hdr(0, 1); req[1] = 1; set_hdr(1, 2); step("R6 occupy");
        idle_inputs(); req[2] = 1; set_hdr(2, 40); step("R6 waiting");
        step("R6 still waiting");
        eop[0] = 1; step("R9 release out1"); eop[0] = 0;
        step("R6 granted after free");
        release_all("R9");

        // R7: contention for output 3 rotates
        req = 4'b0111; for (int i = 0; i < 3; i++) set_hdr(i, 3);
        step("R7 first winner");
        eop[0] = 1; req[0] = 0; step("R7 release"); eop[0] = 0;
        step("R7 second winner");
        eop[1] = 1; req[1] = 0; step("R7 release"); eop[1] = 0;
        step("R7 third winner");
        release_all("R9");

        // R8: hold under changing inputs
        req[0] = 1; set_hdr(0, 40); step("R8 connect");
        set_hdr(0, 3); link_ok = 4'b0001; req = '1; step("R8 hold");
        link_ok = '1; idle_inputs(); step("R8 hold");
        release_all("R9");

        // random phase
        tbl_we = 1; tbl_addr = 8'd32; tbl_mask = 4'b0011; step("R10");
        tbl_addr = 8'd33; tbl_mask = 4'b1100; step("R10");
        tbl_addr = 8'd34; tbl_mask = 4'b0110; step("R10");
        tbl_we = 0;
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                int r;
                r = int'($urandom % 8);
                set_hdr(i, (r < 4) ? r : (r == 4) ? 9 : 32 + r - 5);
                req[i] = ($urandom % 3) != 0;
                eop[i] = ($urandom % 6) == 0;
                eep[i] = ($urandom % 20) == 0;
            end
            link_ok = (($urandom % 6) == 0) ? N'($urandom) : '1;
            tbl_we = ($urandom % 50) == 0;
            tbl_addr = HDR_W'(30 + $urandom % 6);
            tbl_mask = N'($urandom);
            step("R8 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule